// File: doc/BRIEF.md
# Registered Bitwise Logic Unit

This block computes one of eight bitwise functions of two operand vectors of equal width and captures the answer in a result register on the rising clock edge. The register drives the output port. A three-bit selector picks the function. Its two upper bits choose one of four base functions: pass A, AND, OR or XOR. Its lowest bit turns the chosen base result into its complement.

The datapath is a single-bit slice that a generate loop replicates once per bit. All slices share one decoder. The decoder turns the two upper selector bits into a one-hot set of base enables. Each slice combines the base terms through an AND-OR network and then passes the result through one XOR that applies the inversion. There are no states to sequence. The only storage is the result register, with a synchronous reset and a load enable.

Top module: `bitwise_logic_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `result` becomes all zeros after that edge, whatever `load_en`, `fsel` and the operands are.
- R2: When `rst` is low and `load_en` is low at a rising edge, `result` keeps its previous value, whatever `fsel` and the operands are.
- R3: Selector 3'b000 loads `opnd_a`, and 3'b001 loads `~opnd_a`. In both cases `opnd_b` has no effect.
- R4: Selector 3'b010 loads `opnd_a & opnd_b`, and 3'b011 loads `~(opnd_a & opnd_b)`.
- R5: Selector 3'b100 loads `opnd_a | opnd_b`, and 3'b101 loads `~(opnd_a | opnd_b)`.
- R6: Selector 3'b110 loads `opnd_a ^ opnd_b`, and 3'b111 loads `~(opnd_a ^ opnd_b)`.
- R7: For the same operands, setting `fsel[0]` to 1 gives the exact bitwise complement of the value loaded with `fsel[0]` at 0.
- R8: A load takes effect at the rising edge where `load_en` is high. From then on, `result` equals the function of the selector and operands present at that edge.
- R9: Bit i of `result` depends only on bit i of the two operands. A walking-one pattern produces its function at that bit position alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the result register |
| load_en | input | 1 | When high, the register takes the new function result |
| fsel | input | 3 | Function selector: [2:1] choose the base function, [0] inverts it |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| result | output | WIDTH | Registered function result |

## Verification
Each result is due exactly one rising edge after its stimulus, because there is a single register between the operands and `result`. A reset or a held load shows at the same edge. The bench changes inputs on the falling edge and reads `result` on the next falling edge. Every check therefore samples half a period after the single capturing edge and never at an edge. Hold checks read `result` again after several idle edges that carry different operands, to show that nothing moved.

// File: rtl/logic_unit_pkg.sv
package logic_unit_pkg;

    localparam int SEL_W      = 3;
    localparam int BASE_W     = 2;
    localparam int NUM_BASE   = 1 << BASE_W;

    // Base functions chosen by fsel[2:1]; fsel[0] inverts.
    typedef enum logic [BASE_W-1:0] {
        BASE_PASS = 2'd0,
        BASE_AND  = 2'd1,
        BASE_OR   = 2'd2,
        BASE_XOR  = 2'd3
    } base_fn_e;

endpackage

// File: rtl/lu_base_decode.sv
module lu_base_decode
    import logic_unit_pkg::*;
(
    input  base_fn_e              code,
    output logic [NUM_BASE-1:0]   base_en
);

    for (genvar k = 0; k < NUM_BASE; k++) begin : g_dec
        assign base_en[k] = (code == base_fn_e'(BASE_W'(k)));
    end

endmodule

// File: rtl/lu_bit_slice.sv
module lu_bit_slice
    import logic_unit_pkg::*;
(
    input  logic                a_bit,
    input  logic                b_bit,
    input  logic [NUM_BASE-1:0] base_en,
    input  logic                invert,
    output logic                y_bit
);

    logic [NUM_BASE-1:0] term;
    logic                base_val;

    always_comb begin
        term[BASE_PASS] = a_bit            & base_en[BASE_PASS];
        term[BASE_AND]  = (a_bit & b_bit)  & base_en[BASE_AND];
        term[BASE_OR]   = (a_bit | b_bit)  & base_en[BASE_OR];
        term[BASE_XOR]  = (a_bit ^ b_bit)  & base_en[BASE_XOR];
        base_val        = |term;
        y_bit           = base_val ^ invert;
    end

endmodule

// File: rtl/lu_result_reg.sv
module lu_result_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= d;
    end

    // R1: synchronous reset clears the register
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

    // R2: register holds while the enable is low
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));

endmodule

// File: rtl/bitwise_logic_unit.sv
module bitwise_logic_unit
    import logic_unit_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [2:0]       fsel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result
);

    if (WIDTH < 1) begin : g_width_check
        $error("bitwise_logic_unit: WIDTH must be at least 1");
    end

    logic [NUM_BASE-1:0] base_en;
    logic [WIDTH-1:0]    next_val;
    base_fn_e            base_code;

    assign base_code = base_fn_e'(fsel[SEL_W-1:1]);

    lu_base_decode u_decode (
        .code    (base_code),
        .base_en (base_en)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        lu_bit_slice u_slice (
            .a_bit   (opnd_a[i]),
            .b_bit   (opnd_b[i]),
            .base_en (base_en),
            .invert  (fsel[0]),
            .y_bit   (next_val[i])
        );
    end

    lu_result_reg #(.WIDTH(WIDTH)) u_reg (
        .clk (clk),
        .rst (rst),
        .en  (load_en),
        .d   (next_val),
        .q   (result)
    );

    // R8: a load captures the slice outputs of that edge
    assert_load_captures_R8: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (result == $past(next_val)));

    // R4: NAND code yields the complement of the operand AND
    assert_nand_value_R4: assert property (@(posedge clk) disable iff (rst)
        (load_en && fsel == 3'b011) |=> (result == ~($past(opnd_a) & $past(opnd_b))));

    // R6: XNOR code yields the complement of the operand XOR
    assert_xnor_value_R6: assert property (@(posedge clk) disable iff (rst)
        (load_en && fsel == 3'b111) |=> (result == ~($past(opnd_a) ^ $past(opnd_b))));

    // R3: pass code ignores the second operand
    assert_pass_value_R3: assert property (@(posedge clk) disable iff (rst)
        (load_en && fsel == 3'b000) |=> (result == $past(opnd_a)));

endmodule

// File: tb/bitwise_logic_unit_tb.sv
module bitwise_logic_unit_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         load_en;
    logic [2:0]   fsel;
    logic [W-1:0] opnd_a;
    logic [W-1:0] opnd_b;
    logic [W-1:0] result;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    bitwise_logic_unit #(.WIDTH(W)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .fsel    (fsel),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .result  (result)
    );

    function automatic logic [W-1:0] ref_fn(input logic [2:0] s,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
        case (s)
            3'b000: return a;
            3'b001: return ~a;
            3'b010: return a & b;
            3'b011: return ~(a & b);
            3'b100: return a | b;
            3'b101: return ~(a | b);
            3'b110: return a ^ b;
            default: return ~(a ^ b);
        endcase
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] exp);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s: result=%h expected=%h", tag, result, exp);
        end
    endtask

    // drive on falling edge, capture at the rising edge, read at next falling edge
    task automatic step(input logic r, input logic en, input logic [2:0] s,
                        input logic [W-1:0] a, input logic [W-1:0] b);
        rst = r; load_en = en; fsel = s; opnd_a = a; opnd_b = b;
        @(negedge clk);
    endtask

    task automatic t_reset();
        step(1'b0, 1'b1, 3'b000, 4'hF, 4'h0);
        step(1'b1, 1'b1, 3'b001, 4'h0, 4'h0);
        chk("R1 reset clears", '0);
    endtask

    task automatic t_pass_not();
        step(1'b0, 1'b1, 3'b000, 4'hA, 4'h5);
        chk("R3 pass", 4'hA);
        step(1'b0, 1'b1, 3'b000, 4'hA, 4'hF);
        chk("R3 pass b ignored", 4'hA);
        step(1'b0, 1'b1, 3'b001, 4'hC, 4'h3);
        chk("R3 not", 4'h3);
    endtask

    task automatic t_and_nand();
        step(1'b0, 1'b1, 3'b010, 4'hC, 4'hA);
        chk("R4 and", 4'h8);
        step(1'b0, 1'b1, 3'b011, 4'hC, 4'hA);
        chk("R4 nand", 4'h7);
    endtask

    task automatic t_or_nor();
        step(1'b0, 1'b1, 3'b100, 4'hC, 4'hA);
        chk("R5 or", 4'hE);
        step(1'b0, 1'b1, 3'b101, 4'hC, 4'hA);
        chk("R5 nor", 4'h1);
    endtask

    task automatic t_xor_xnor();
        step(1'b0, 1'b1, 3'b110, 4'hC, 4'hA);
        chk("R6 xor", 4'h6);
        step(1'b0, 1'b1, 3'b111, 4'hC, 4'hA);
        chk("R6 xnor", 4'h9);
    endtask

    task automatic t_invert_pair();
        for (int s = 0; s < 8; s += 2) begin
            logic [W-1:0] a = W'($urandom);
            logic [W-1:0] b = W'($urandom);
            logic [W-1:0] plain;
            step(1'b0, 1'b1, 3'(s), a, b);
            plain = result;
            step(1'b0, 1'b1, 3'(s + 1), a, b);
            chk("R7 invert bit complements", ~plain);
        end
    endtask

    task automatic t_hold();
        step(1'b0, 1'b1, 3'b110, 4'h5, 4'h3);
        chk("R8 load", 4'h6);
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b0, 3'(k), 4'(k * 3), 4'hF);
            chk("R2 hold while idle", 4'h6);
        end
    endtask

    task automatic t_walking();
        for (int i = 0; i < W; i++) begin
            logic [W-1:0] one = W'(1) << i;
            step(1'b0, 1'b1, 3'b110, one, '0);
            chk("R9 walking xor", one);
            step(1'b0, 1'b1, 3'b011, one, one);
            chk("R9 walking nand", ~one);
        end
    endtask

    task automatic t_sweep();
        for (int n = 0; n < 64; n++) begin
            logic [2:0]   s = 3'(n % 8);
            logic [W-1:0] a = W'($urandom);
            logic [W-1:0] b = W'($urandom);
            step(1'b0, 1'b1, s, a, b);
            chk("R8 sweep against model", ref_fn(s, a, b));
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected=<5000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; load_en = 1'b0; fsel = '0; opnd_a = '0; opnd_b = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 initial reset", '0);
        t_reset();
        t_pass_not();
        t_and_nand();
        t_or_nor();
        t_xor_xnor();
        t_invert_pair();
        t_hold();
        t_walking();
        t_sweep();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule